// File: doc/BRIEF.md
# DMA Channel Address Generator

This block holds the address and count datapath of one channel of a legacy style DMA controller. A 16-bit address counter is paired with an 8-bit page register, and together they form a 24-bit physical address. A channel is either a byte channel or a word channel. On a word channel the counter is shifted left by one bit, so that each step moves one 16-bit word and one operation can cover up to 128K bytes.

Software loads a base address, a base count, a page, the channel type and an auto-initialise flag in one load cycle. Each transfer strobe then advances the address by one step and lowers the count by one. The count is loaded as the number of transfers minus one. When a strobe arrives with the count at zero, terminal count is raised. The channel then either stops or, with auto-initialise set, reloads its base values and stays active. The address counter wraps inside its 16 bits and never carries into the page, so a transfer stays inside one 64K page (byte channel) or one 128K page (word channel).

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the channel is inactive, `cur_cnt` is 0, `phys_addr` is 0 and `tc` is 0.
- R2: One clock edge after `ld_en` is high, `active` is 1, `cur_cnt` equals the loaded base count and the address counter equals the loaded base address.
- R3: With `ld_word`=0 (byte channel), `phys_addr[23:16]` is the page and `phys_addr[15:0]` is the address counter.
- R4: With `ld_word`=1 (word channel), `phys_addr[0]` is 0, `phys_addr[16:1]` is the address counter and `phys_addr[23:17]` is page bits 7:1. Page bit 0 has no effect.
- R5: A strobe on `xfer` while active, with no load in the same cycle, raises the address counter by one and lowers `cur_cnt` by one at the next edge.
- R6: The address counter wraps from 0xFFFF to 0x0000 without changing any page-derived bit of `phys_addr`.
- R7: `tc` is high in the same cycle as an accepted strobe that finds `cur_cnt` at 0. Without auto-initialise, `cur_cnt` then reads 0xFFFF.
- R8: Without auto-initialise, the channel goes inactive after terminal count. While the channel is inactive, strobes leave `cur_cnt` and `phys_addr` unchanged and do not raise `tc`.
- R9: With `ld_autoinit`=1, terminal count reloads the address counter and `cur_cnt` from their base values, and the channel stays active.
- R10: `rem_bytes` equals (`cur_cnt` + 1) modulo 65536 on a byte channel, and twice that value on a word channel.
- R11: A load in the same cycle as a strobe wins. The strobe is dropped and `tc` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load strobe for all base values |
| ld_base_addr | input | 16 | Base (start) address counter value |
| ld_base_cnt | input | 16 | Base count, number of transfers minus one |
| ld_page | input | 8 | Page register value |
| ld_word | input | 1 | Channel type: 0 byte, 1 word |
| ld_autoinit | input | 1 | Reload base values at terminal count |
| xfer | input | 1 | Transfer strobe, one step per cycle high |
| phys_addr | output | 24 | Physical address of the current transfer |
| tc | output | 1 | Terminal count, same cycle as the last strobe |
| cur_cnt | output | 16 | Current count register |
| rem_bytes | output | 17 | Bytes still to move |
| active | output | 1 | Channel accepts strobes |

## Verification
`tc` is a combinational result of the current state and the strobe. It is due in the cycle the strobe is driven, so the driver samples it one nanosecond after driving, well before the next rising edge. `phys_addr`, `cur_cnt`, `rem_bytes` and `active` change on the rising edge that follows a load or strobe. For each stimulus the driver queues the expected values after that edge. The monitor pops one queued item per edge and compares it two nanoseconds after the edge, so each compare lines up with exactly one register update.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
    localparam int unsigned AW  = 16;
    localparam int unsigned PW  = 8;
    localparam int unsigned PHW = AW + PW;

    typedef enum logic {
        CH_BYTE = 1'b0,
        CH_WORD = 1'b1
    } ch_kind_e;

    typedef struct packed {
        logic [AW-1:0] base_addr;
        logic [AW-1:0] base_cnt;
        logic [AW-1:0] cur_addr;
        logic [AW-1:0] cur_cnt;
        logic [PW-1:0] page;
        ch_kind_e      kind;
        logic          auto_init;
        logic          active;
    } chan_state_t;
endpackage

// File: rtl/dma_agen_phys_map.sv
module dma_agen_phys_map
    import dma_agen_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAGE_W = 8,
    localparam int unsigned OUT_W = ADDR_W + PAGE_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    input  ch_kind_e          kind,
    output logic [OUT_W-1:0]  phys
);
    // byte: page above counter; word: counter shifted, page bit 0 dropped
    always_comb begin
        if (kind == CH_WORD) begin
            phys = {page[PAGE_W-1:1], addr, 1'b0};
        end else begin
            phys = {page, addr};
        end
    end
endmodule

// File: rtl/dma_agen_residue.sv
module dma_agen_residue
    import dma_agen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  ch_kind_e         kind,
    output logic [CNT_W:0]   bytes_left
);
    logic [CNT_W-1:0] xfers_left;

    always_comb begin
        xfers_left = cnt + CNT_W'(1);
        if (kind == CH_WORD) begin
            bytes_left = {xfers_left, 1'b0};
        end else begin
            bytes_left = {1'b0, xfers_left};
        end
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_agen_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_en,
    input  logic [AW-1:0]  ld_base_addr,
    input  logic [AW-1:0]  ld_base_cnt,
    input  logic [PW-1:0]  ld_page,
    input  logic           ld_word,
    input  logic           ld_autoinit,
    input  logic           xfer,
    output logic [PHW-1:0] phys_addr,
    output logic           tc,
    output logic [AW-1:0]  cur_cnt,
    output logic [AW:0]    rem_bytes,
    output logic           active
);
    chan_state_t st_d, st_q;
    logic        step_ok;
    logic        last_step;

    always_comb begin
        st_d      = st_q;
        step_ok   = xfer && st_q.active && !ld_en;
        last_step = step_ok && (st_q.cur_cnt == '0);

        if (ld_en) begin
            st_d.base_addr = ld_base_addr;
            st_d.base_cnt  = ld_base_cnt;
            st_d.cur_addr  = ld_base_addr;
            st_d.cur_cnt   = ld_base_cnt;
            st_d.page      = ld_page;
            st_d.kind      = ld_word ? CH_WORD : CH_BYTE;
            st_d.auto_init = ld_autoinit;
            st_d.active    = 1'b1;
        end else if (step_ok) begin
            if (last_step && st_q.auto_init) begin
                st_d.cur_addr = st_q.base_addr;
                st_d.cur_cnt  = st_q.base_cnt;
            end else begin
                st_d.cur_addr = st_q.cur_addr + AW'(1);
                st_d.cur_cnt  = st_q.cur_cnt - AW'(1);
                if (last_step) begin
                    st_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dma_agen_phys_map #(
        .ADDR_W (AW),
        .PAGE_W (PW)
    ) u_map (
        .page (st_q.page),
        .addr (st_q.cur_addr),
        .kind (st_q.kind),
        .phys (phys_addr)
    );

    dma_agen_residue #(
        .CNT_W (AW)
    ) u_res (
        .cnt        (st_q.cur_cnt),
        .kind       (st_q.kind),
        .bytes_left (rem_bytes)
    );

    assign tc      = last_step;
    assign cur_cnt = st_q.cur_cnt;
    assign active  = st_q.active;
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk
    import dma_agen_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           ld_en,
    input logic [AW-1:0]  ld_base_cnt,
    input logic           ld_word,
    input logic           xfer,
    input logic           tc,
    input logic           active,
    input logic [AW-1:0]  cur_cnt,
    input logic [PHW-1:0] phys_addr
);
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (active && cur_cnt == $past(ld_base_cnt)));

    assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_word) |=> (phys_addr[0] == 1'b0));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && active && !ld_en && cur_cnt != '0) |=> (cur_cnt == $past(cur_cnt) - AW'(1)));

    assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !ld_en) |=> (phys_addr[PHW-1:AW+1] == $past(phys_addr[PHW-1:AW+1])));

    assert_after_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (active || cur_cnt == '1));

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !ld_en) |=> (!active && $stable(cur_cnt) && $stable(phys_addr)));

    assert_no_tc_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !tc);
endmodule

bind dma_addr_gen dma_addr_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_en       (ld_en),
    .ld_base_cnt (ld_base_cnt),
    .ld_word     (ld_word),
    .xfer        (xfer),
    .tc          (tc),
    .active      (active),
    .cur_cnt     (cur_cnt),
    .phys_addr   (phys_addr)
);

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_en, ld_word, ld_autoinit, xfer;
    logic [15:0] ld_base_addr, ld_base_cnt;
    logic [7:0]  ld_page;
    logic [23:0] phys_addr;
    logic        tc;
    logic [15:0] cur_cnt;
    logic [16:0] rem_bytes;
    logic        active;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        string       tag;
        logic [23:0] ph;
        logic [15:0] cnt;
        logic        act;
        logic [16:0] rem;
    } exp_t;
    exp_t sb[$];

    // reference state kept by the bench
    logic [15:0] m_baddr, m_bcnt, m_addr, m_cnt;
    logic [7:0]  m_page;
    logic        m_word, m_auto, m_act;

    always #4 clk = ~clk;

    dma_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_base_addr(ld_base_addr),
        .ld_base_cnt(ld_base_cnt), .ld_page(ld_page), .ld_word(ld_word),
        .ld_autoinit(ld_autoinit), .xfer(xfer), .phys_addr(phys_addr), .tc(tc),
        .cur_cnt(cur_cnt), .rem_bytes(rem_bytes), .active(active)
    );

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [23:0] exp_phys();
        int unsigned v;
        if (m_word) v = (int'(m_page) & 32'hFE) * 65536 + int'(m_addr) * 2;
        else        v = int'(m_page) * 65536 + int'(m_addr);
        return v[23:0];
    endfunction

    function automatic logic [16:0] exp_rem();
        int unsigned r;
        r = (int'(m_cnt) + 1) % 65536;
        if (m_word) r = r * 2;
        return r[16:0];
    endfunction

    // driver: apply one cycle of stimulus, check tc now, queue post-edge state
    task automatic step(string tag, logic ld, logic [15:0] ba, logic [15:0] bc,
                        logic [7:0] pg, logic wd, logic au, logic x);
        exp_t it;
        logic exp_tc;
        @(negedge clk);
        ld_en = ld; ld_base_addr = ba; ld_base_cnt = bc; ld_page = pg;
        ld_word = wd; ld_autoinit = au; xfer = x;
        exp_tc = x && m_act && !ld && (m_cnt == 16'h0000);
        #1;
        chk(tag, "tc", {31'b0, tc}, {31'b0, exp_tc});
        if (ld) begin
            m_baddr = ba; m_bcnt = bc; m_addr = ba; m_cnt = bc;
            m_page = pg; m_word = wd; m_auto = au; m_act = 1'b1;
        end else if (x && m_act) begin
            if (exp_tc && m_auto) begin
                m_addr = m_baddr; m_cnt = m_bcnt;
            end else begin
                m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
                if (exp_tc) m_act = 1'b0;
            end
        end
        it.tag = tag; it.ph = exp_phys(); it.cnt = m_cnt; it.act = m_act; it.rem = exp_rem();
        sb.push_back(it);
    endtask

    // monitor: one queued item per rising edge, compared 2 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                chk(it.tag, "phys_addr", {8'b0, phys_addr}, {8'b0, it.ph});
                chk(it.tag, "cur_cnt", {16'b0, cur_cnt}, {16'b0, it.cnt});
                chk(it.tag, "active", {31'b0, active}, {31'b0, it.act});
                chk({it.tag, "/R10"}, "rem_bytes", {15'b0, rem_bytes}, {15'b0, it.rem});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ld_en = 0; ld_word = 0; ld_autoinit = 0; xfer = 0;
        ld_base_addr = 0; ld_base_cnt = 0; ld_page = 0;
        m_baddr = 0; m_bcnt = 0; m_addr = 0; m_cnt = 0; m_page = 0;
        m_word = 0; m_auto = 0; m_act = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1", "active", {31'b0, active}, 32'd0);
        chk("R1", "cur_cnt", {16'b0, cur_cnt}, 32'd0);
        chk("R1", "phys_addr", {8'b0, phys_addr}, 32'd0);
        chk("R1", "tc", {31'b0, tc}, 32'd0);

        // R8: strobe before any load is ignored
        step("R8", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        // R2/R3: byte channel load, three transfers
        step("R2", 1, 16'h1234, 16'h0002, 8'h5A, 0, 0, 0);
        step("R3", 0, 16'h0, 16'h0, 8'h0, 0, 0, 0);
        step("R5", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R5", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R7", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R8", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R8", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        // R4/R9: word channel, odd page, auto-initialise, address at top of range
        step("R4", 1, 16'hFFFF, 16'h0003, 8'h37, 1, 1, 0);
        step("R6", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R5", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R5", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R9", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R9", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        // R11: load and strobe together, full 64K count (residue wraps to 0)
        step("R11", 1, 16'h0000, 16'hFFFF, 8'h01, 0, 0, 1);
        step("R5", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        // R6: byte channel wraps inside its page
        step("R6", 1, 16'hFFFF, 16'h0005, 8'h80, 0, 0, 0);
        step("R6", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R6", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        // R11 at terminal count: load on the strobe that would end the transfer
        step("R11", 1, 16'h0100, 16'h0000, 8'h02, 0, 0, 0);
        step("R11", 1, 16'h0200, 16'h0001, 8'h03, 1, 0, 1);
        step("R7", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R7", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R8", 0, 16'h0, 16'h0, 8'h0, 0, 0, 1);
        step("R8", 0, 16'h0, 16'h0, 8'h0, 0, 0, 0);
        wait (sb.size() == 0);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule